// File: doc/BRIEF.md
# Target-Ready Timeout and Retry Controller

This block watches the outbound transfers of a bus bridge while the bridge is acting as master. It guards against two failures. The first is a stalled data phase, where the target keeps its ready signal low for too long. The second is a target that keeps disconnecting. A stall counter is compared with a programmable cycle limit, and an attempt counter is compared with a programmable retry limit.

The two kinds of transfer end differently once their retries run out:

- **Reads.** Once the first retry stage is used up, the block waits until the bridge reports that pending writes and read returns have drained. It then runs a second retry stage, bounded by its own bypass count. If that stage also fails, the read is aborted and a bus-error response is returned to the internal bus.
- **Writes.** Once the retries run out, the write is discarded.

Each failure sets a sticky status bit and pulses an interrupt request.

Top module: `trdy_retry_ctrl`

## Requirements
- R1: After reset, `reissue`, `abort`, `bus_err_rsp`, `irq`, `trdy_err` and `retry_err` are all 0 and no transfer is in progress.
- R2: During an attempt, `abort` is pulsed when `tgt_ready` has been low for `trdy_limit`+1 consecutive cycles without `done` or `disc`, and `trdy_err` is set. With a limit of 3, the abort follows the fourth low cycle.
- R3: The stall count restarts when `tgt_ready` is sampled high, and when a new attempt begins after a disconnect.
- R4: Every abort of a read asserts `bus_err_rsp` together with `abort`. An abort of a write never asserts `bus_err_rsp`.
- R5: A disconnect (`disc`=1) is answered by a one-cycle `reissue` pulse while fewer attempts than the active limit have been made in the current stage.
- R6: A `retry_limit` or `bypass_count` of 0 counts as 1, so each stage makes at least one attempt.
- R7: After a read uses up `retry_limit` attempts, no `reissue` is produced while `drain_empty` is 0. The first cycle that samples `drain_empty`=1 starts the second stage with a `reissue`.
- R8: A read that also fails its last second-stage attempt is aborted with `bus_err_rsp`, and `retry_err` is set. A read therefore makes limit1+limit2 attempts in total.
- R9: A write that is disconnected on its last allowed attempt is discarded: `abort` without `bus_err_rsp`, with `retry_err` set. No second stage is run for writes.
- R10: `trdy_err` and `retry_err` stay set until `err_clr` bit 0 or bit 1 (respectively) is 1. If a set and a clear arrive in the same cycle, the bit stays set.
- R11: Every error event produces a single-cycle `irq` pulse.
- R12: `done` ends the transfer with no abort and no reissue, and `done` wins over `disc` and over a stall in the same cycle.
- R13: `xfer_start` and `xfer_is_read` are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Starts supervision of a new transfer (accepted only when idle) |
| xfer_is_read | input | 1 | 1 = read, 0 = write; captured with `xfer_start` |
| tgt_ready | input | 1 | Target ready sampled in the current data cycle |
| disc | input | 1 | Current attempt ended with a disconnect or retry |
| done | input | 1 | Transfer completed successfully |
| drain_empty | input | 1 | Pending writes and read returns have drained |
| trdy_limit | input | CW | Stall limit in bus cycles |
| retry_limit | input | CW | First-stage attempt limit |
| bypass_count | input | CW | Second-stage attempt limit for reads |
| err_clr | input | 2 | Write-one-to-clear: bit 0 clears `trdy_err`, bit 1 clears `retry_err` |
| reissue | output | 1 | Pulse: re-issue the transfer |
| abort | output | 1 | Pulse: the transfer is abandoned |
| bus_err_rsp | output | 1 | Pulse with `abort` on reads: return data marked as bus error |
| irq | output | 1 | Interrupt request pulse on an error event |
| trdy_err | output | 1 | Sticky stall-timeout status |
| retry_err | output | 1 | Sticky retry-exhaustion status |

## Verification
Every decision is made from inputs sampled at one rising edge and is registered. As a result, `reissue`, `abort`, `bus_err_rsp`, `irq` and the status bits all show their new values in the cycle that follows the deciding edge. The bench drives stimulus at a falling edge and samples outputs at the next falling edge, so each sample lands exactly one cycle after the deciding edge. For the stall limit, it counts the low cycles of `tgt_ready` itself and expects the abort only after the (limit+1)th low cycle.

// File: rtl/trdy_retry_ctrl.sv
module trdy_retry_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_start,
  input  logic          xfer_is_read,
  input  logic          tgt_ready,
  input  logic          disc,
  input  logic          done,
  input  logic          drain_empty,
  input  logic [CW-1:0] trdy_limit,
  input  logic [CW-1:0] retry_limit,
  input  logic [CW-1:0] bypass_count,
  input  logic [1:0]    err_clr,
  output logic          reissue,
  output logic          abort,
  output logic          bus_err_rsp,
  output logic          irq,
  output logic          trdy_err,
  output logic          retry_err
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_DRAIN = 2'd2} st_t;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  st_t           st;
  logic          rd_q, ph2_q;
  logic [CW-1:0] att_q, stall_q;

  wire [CW-1:0] lim1 = (retry_limit == '0) ? ONE : retry_limit;
  wire [CW-1:0] lim2 = (bypass_count == '0) ? ONE : bypass_count;
  wire [CW-1:0] lim  = ph2_q ? lim2 : lim1;
  wire more     = att_q < lim;
  wire run      = (st == S_RUN) && !done;
  wire ev_retry = run && disc && more;
  wire ev_drain = run && disc && !more && rd_q && !ph2_q;
  wire ev_rfail = run && disc && !more && !(rd_q && !ph2_q);
  wire ev_tmo   = run && !disc && !tgt_ready && (stall_q >= trdy_limit);
  wire ev_res   = (st == S_DRAIN) && drain_empty;
  wire ev_fail  = ev_rfail || ev_tmo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rd_q        <= 1'b0;
      ph2_q       <= 1'b0;
      att_q       <= '0;
      stall_q     <= '0;
      reissue     <= 1'b0;
      abort       <= 1'b0;
      bus_err_rsp <= 1'b0;
      irq         <= 1'b0;
      trdy_err    <= 1'b0;
      retry_err   <= 1'b0;
    end else begin
      reissue     <= ev_retry || ev_res;
      abort       <= ev_fail;
      bus_err_rsp <= ev_fail && rd_q;
      irq         <= ev_fail;
      trdy_err    <= ev_tmo   || (trdy_err  && !err_clr[0]);
      retry_err   <= ev_rfail || (retry_err && !err_clr[1]);
      case (st)
        S_IDLE: if (xfer_start) begin
          st      <= S_RUN;
          rd_q    <= xfer_is_read;
          ph2_q   <= 1'b0;
          att_q   <= ONE;
          stall_q <= '0;
        end
        S_RUN: begin
          if (done || ev_fail) st <= S_IDLE;
          else if (ev_retry) begin
            att_q   <= att_q + ONE;
            stall_q <= '0;
          end else if (ev_drain) st <= S_DRAIN;
          else stall_q <= tgt_ready ? '0 : stall_q + ONE;
        end
        S_DRAIN: if (drain_empty) begin
          st      <= S_RUN;
          ph2_q   <= 1'b1;
          att_q   <= ONE;
          stall_q <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module trdy_retry_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reissue,
  input logic       abort,
  input logic       bus_err_rsp,
  input logic       irq,
  input logic       trdy_err,
  input logic       retry_err,
  input logic       drain_empty,
  input logic [1:0] err_clr,
  input logic [1:0] st
);
  localparam logic [1:0] DRAIN_ST = 2'd2;

  AST_BUSERR_NEEDS_ABORT: assert property (@(posedge clk) disable iff (!rst_n) bus_err_rsp |-> abort); // R4
  AST_REISSUE_EXCL_ABORT: assert property (@(posedge clk) disable iff (!rst_n) !(reissue && abort)); // R5
  AST_TRDY_ERR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n) $rose(trdy_err) |-> abort); // R2
  AST_RETRY_ERR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n) $rose(retry_err) |-> abort); // R8
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (st == DRAIN_ST && !drain_empty) |=> !reissue); // R7
  AST_TRDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (trdy_err && !err_clr[0]) |=> trdy_err); // R10
  AST_RETRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (retry_err && !err_clr[1]) |=> retry_err); // R10
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R11
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) abort |=> !abort); // R12
endmodule

bind trdy_retry_ctrl trdy_retry_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reissue(reissue), .abort(abort),
  .bus_err_rsp(bus_err_rsp), .irq(irq), .trdy_err(trdy_err),
  .retry_err(retry_err), .drain_empty(drain_empty), .err_clr(err_clr), .st(st)
);

// File: tb/trdy_retry_ctrl_tb.sv
module trdy_retry_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer_start = 0, xfer_is_read = 0, tgt_ready = 1, disc = 0, done = 0, drain_empty = 1;
  logic [7:0] trdy_limit = 8'h80, retry_limit = 8'h80, bypass_count = 8'h01;
  logic [1:0] err_clr = 2'b00;
  logic reissue, abort, bus_err_rsp, irq, trdy_err, retry_err;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trdy_retry_ctrl #(.CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
    .tgt_ready(tgt_ready), .disc(disc), .done(done), .drain_empty(drain_empty),
    .trdy_limit(trdy_limit), .retry_limit(retry_limit), .bypass_count(bypass_count),
    .err_clr(err_clr), .reissue(reissue), .abort(abort), .bus_err_rsp(bus_err_rsp),
    .irq(irq), .trdy_err(trdy_err), .retry_err(retry_err)
  );

  // {read, retry_limit, bypass_count, expected reissues}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'd3, 8'd0, 8'd2},
    {1'b0, 8'd0, 8'd0, 8'd0},
    {1'b1, 8'd2, 8'd3, 8'd4},
    {1'b1, 8'd0, 8'd0, 8'd1},
    {1'b1, 8'd1, 8'd2, 8'd2},
    {1'b0, 8'd1, 8'd5, 8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic start(input logic rd);
    xfer_is_read = rd; xfer_start = 1; cyc(); xfer_start = 0;
  endtask

  task automatic clr_all();
    err_clr = 2'b11; cyc(); err_clr = 2'b00;
  endtask

  task automatic run_retry(input logic rd, input logic [7:0] rl, input logic [7:0] bc,
                           output int n, output logic be, output logic re, output logic iq);
    bit fin = 0;
    retry_limit = rl; bypass_count = bc; trdy_limit = 8'hFF; tgt_ready = 1; drain_empty = 1;
    n = 0; be = 0; re = 0; iq = 0;
    start(rd);
    for (int g = 0; g < 600 && !fin; g++) begin
      disc = 1; cyc(); disc = 0;
      if (abort) begin be = bus_err_rsp; re = retry_err; iq = irq; fin = 1; end
      else if (reissue) n++;
      else begin cyc(); if (reissue) n++; else begin n = -1; fin = 1; end end
    end
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n; logic be, re, iq;
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk("R1 reissue", reissue, 0); chk("R1 abort", abort, 0); chk("R1 bus_err", bus_err_rsp, 0);
    chk("R1 irq", irq, 0); chk("R1 trdy_err", trdy_err, 0); chk("R1 retry_err", retry_err, 0);

    // Table: R5 R6 R8 R9 R4 R11
    foreach (VEC[i]) begin
      run_retry(VEC[i][24], VEC[i][23:16], VEC[i][15:8], n, be, re, iq);
      chk($sformatf("R5_R6_R8_R9 reissue count vec%0d", i), n, int'(VEC[i][7:0]));
      chk($sformatf("R4 bus_err vec%0d", i), be, VEC[i][24]);
      chk($sformatf("R9 retry_err vec%0d", i), re, 1);
      chk($sformatf("R11 irq vec%0d", i), iq, 1);
      clr_all();
    end

    // R2 stall timeout on a read, limit 3
    trdy_limit = 3; retry_limit = 4; start(1);
    for (int k = 0; k <= 3; k++) begin
      tgt_ready = 0; cyc();
      chk("R2 abort timing", abort, k == 3);
    end
    chk("R4 read timeout bus_err", bus_err_rsp, 1);
    chk("R2 trdy_err", trdy_err, 1);
    chk("R11 irq", irq, 1);
    tgt_ready = 1; cyc();
    chk("R11 irq single cycle", irq, 0);
    chk("R10 trdy_err sticky", trdy_err, 1);
    err_clr = 2'b10; cyc(); err_clr = 0;
    chk("R10 wrong clear bit", trdy_err, 1);
    err_clr = 2'b01; cyc(); err_clr = 0;
    chk("R10 cleared", trdy_err, 0);

    // R3 stall count restarts on ready and on new attempt (write, limit 2)
    trdy_limit = 2; start(0);
    tgt_ready = 0; cyc(); cyc();
    tgt_ready = 1; cyc();
    tgt_ready = 0; cyc(); cyc();
    chk("R3 no abort after ready", abort, 0);
    disc = 1; cyc(); disc = 0;
    chk("R3 reissue", reissue, 1);
    tgt_ready = 0; cyc(); cyc();
    chk("R3 no abort after new attempt", abort, 0);
    cyc();
    chk("R3 abort on third low", abort, 1);
    chk("R4 write timeout no bus_err", bus_err_rsp, 0);
    tgt_ready = 1; clr_all();

    // R7 drain wait, then R8 final failure
    trdy_limit = 8'hFF; retry_limit = 1; bypass_count = 1; drain_empty = 0;
    start(1);
    disc = 1; cyc(); disc = 0;
    chk("R7 no reissue at stage end", reissue, 0);
    for (int k = 0; k < 3; k++) begin cyc(); chk("R7 holds while not drained", reissue, 0); end
    drain_empty = 1; cyc();
    chk("R7 reissue after drain", reissue, 1);
    disc = 1; cyc(); disc = 0;
    chk("R8 abort", abort, 1); chk("R8 bus_err", bus_err_rsp, 1); chk("R8 retry_err", retry_err, 1);
    cyc(); clr_all();

    // R10 set wins over clear in same cycle
    trdy_limit = 0; start(0);
    tgt_ready = 0; err_clr = 2'b01; cyc(); err_clr = 0; tgt_ready = 1;
    chk("R10 set wins", trdy_err, 1);
    clr_all();

    // R12 done ends transfer, wins over disc
    trdy_limit = 2; retry_limit = 1; start(1);
    tgt_ready = 0; cyc(); cyc();
    done = 1; disc = 1; cyc(); done = 0; disc = 0;
    chk("R12 no abort on done", abort, 0);
    chk("R12 no reissue on done", reissue, 0);
    for (int k = 0; k < 4; k++) begin cyc(); chk("R12 idle after done", abort, 0); end
    tgt_ready = 1;

    // R13 start ignored while busy
    trdy_limit = 3; start(1);
    tgt_ready = 0; xfer_is_read = 0; xfer_start = 1; cyc(); xfer_start = 0;
    cyc(); cyc(); cyc();
    chk("R13 abort", abort, 1);
    chk("R13 read kept", bus_err_rsp, 1);
    tgt_ready = 1; clr_all();
    chk("R1 errors cleared", trdy_err | retry_err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule